// File: doc/BRIEF.md
# Four-Channel DMA Register Front End

This block is the programmable register set of a four-channel DMA controller. Software reaches it over a byte-wide I/O bus with a 4-bit port index and a page-select line. Each channel holds a 16-bit base address, a 16-bit base count, a count of units already moved, a mode field and a page byte. Shared controller state is a command byte, a status byte of request and terminal-count flags, a four-bit mask and one byte-pointer flip-flop. That flip-flop splits every 16-bit channel register into two byte accesses.

A transfer scheduler sits outside the block. It watches `chan_ready` and each channel's mode. It reports every unit it moves through `xfer_adv`/`xfer_chan` and takes the full address of the unit from `xfer_addr`. The block sets the terminal-count flag itself and reloads the channel when auto-initialise is on. Power-up reset has the same effect as a master-reset port write. The channel registers are also reset to zero.

Top module: `dma4_regfile`

## Requirements
- R1: After `rst_n` is released, status reads 0x00, the mask reads 0x0F, `chan_mask` is 4'hF, `ctl_cmd` is 0 and the byte pointer is clear.
- R2: Ports 0..7 (page select low) address channel `idx[2:1]`: the address register when `idx[0]`=0 and the count register when `idx[0]`=1. Each access to these ports moves the low byte when the byte pointer is clear and the high byte when it is set. The pointer toggles after every such read or write. A write to port 0xC clears it.
- R3: A high-byte write to a channel's address or count register sets that channel's transferred-unit count to zero, so the current address returns to the base address.
- R4: A read of the current address returns base address + transferred units. A read of the current count returns base count − transferred units. Both are taken modulo 2^16.
- R5: A pulse of `xfer_adv` with `xfer_chan`=k adds one to channel k's transferred units. When the count before the increment equals the base count, status bit k (terminal count) is set. If mode bit 2 (auto-initialise) is also set, the transferred units go to 0 instead.
- R6: A port-8 write whose data has any bit of mask 0xFB set is rejected: `ctl_cmd` keeps its value and `cmd_err` is high for the following cycle. Any other value, zero included, is stored in `ctl_cmd`.
- R7: A port-9 write with data[2]=1 sets the request flag of channel data[1:0] (status bit 4+channel). With data[2]=0 it clears that request flag and that channel's terminal-count flag.
- R8: A port-0xA write sets mask bit data[1:0] when data[2]=1 and clears it when data[2]=0.
- R9: A port-0xB write stores data[7:2] as the mode of channel data[1:0]. The mode appears on `chan_mode[6k+5:6k]`.
- R10: A port-0xD write is a master reset: command, request and terminal-count flags go to 0, the byte pointer is cleared and the mask becomes 4'hF. A port-0xE write clears the mask. A port-0xF write loads the mask from data[3:0].
- R11: A read of port 8 returns {request[3:0], terminal count[3:0]}. A read of port 0xF returns {4'h0, mask}.
- R12: A read of ports 9..0xE returns 0xFF and leaves the byte pointer unchanged.
- R13: With `bus_page`=1, a write or read reaches the page byte of channel `idx[1:0]` and does not toggle the byte pointer. `xfer_addr` is {page, base address + transferred units} of channel `xfer_chan`.
- R14: `chan_ready[k]` is high exactly when channel k's request flag is set and its mask bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, acts as master reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_page | input | 1 | Selects the page-register space |
| bus_idx | input | 4 | Port index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current index |
| xfer_adv | input | 1 | One unit moved on channel `xfer_chan` |
| xfer_chan | input | 2 | Channel of the scheduler |
| xfer_addr | output | 24 | Full address of the next unit of `xfer_chan` |
| chan_ready | output | 4 | Request set and not masked, per channel |
| chan_mask | output | 4 | Mask bits |
| chan_mode | output | 24 | Six mode bits per channel |
| ctl_cmd | output | 8 | Accepted command byte |
| cmd_err | output | 1 | Rejected command, one cycle |

## Verification
The hardest state to reach is a terminal count that lands on the same unit as an auto-initialise reload. The pointer has to be even, the mode written and the count programmed before the scheduler pulses arrive. The bench programs a small base count on one channel with auto-initialise set and pulses `xfer_adv` one more time than the count. It then reads the count back through the byte pointer and the status port to show the reload and the flag. It also tracks the pointer's parity through mixed reads, writes, undefined reads and master resets, and checks the parity by which byte comes back.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int NCH   = 4;
    localparam int CHW   = 2;
    localparam int REGW  = 16;
    localparam int MODEW = 6;
    localparam logic [7:0] CMD_REJECT = 8'hFB;

    typedef struct packed {
        logic [7:0]     cmd;
        logic [NCH-1:0] req;
        logic [NCH-1:0] tc;
        logic [NCH-1:0] mask;
        logic           ff;
        logic           err;
    } ctl_t;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_base,
    input  logic             hi_byte,
    input  logic             sel_cnt,
    input  logic [7:0]       wdata,
    input  logic             mode_wr,
    input  logic             page_wr,
    input  logic             adv,
    output logic [REGW-1:0]  cur_addr,
    output logic [REGW-1:0]  cur_cnt,
    output logic [PW-1:0]    page,
    output logic [MODEW-1:0] mode,
    output logic             tc_hit
);
    typedef struct packed {
        logic [REGW-1:0]  base_addr;
        logic [REGW-1:0]  base_cnt;
        logic [REGW-1:0]  done;
        logic [MODEW-1:0] mode;
        logic [PW-1:0]    page;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tc_hit = adv && (st_q.done == st_q.base_cnt);
        if (adv) begin
            if (tc_hit && st_q.mode[2]) st_d.done = '0;
            else                        st_d.done = st_q.done + 1'b1;
        end
        if (wr_base) begin
            if (hi_byte) begin
                if (sel_cnt) st_d.base_cnt[15:8]  = wdata;
                else         st_d.base_addr[15:8] = wdata;
                st_d.done = '0;
            end else begin
                if (sel_cnt) st_d.base_cnt[7:0]  = wdata;
                else         st_d.base_addr[7:0] = wdata;
            end
        end
        if (mode_wr) st_d.mode = wdata[7:2];
        if (page_wr) st_d.page = PW'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = st_q.base_addr + st_q.done;
    assign cur_cnt  = st_q.base_cnt - st_q.done;
    assign page     = st_q.page;
    assign mode     = st_q.mode;

    // R3
    reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_base && hi_byte) |=> (st_q.done == '0));

    // R5
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !(wr_base && hi_byte) && !(st_q.done == st_q.base_cnt && st_q.mode[2]))
        |=> (st_q.done == $past(st_q.done) + 1'b1));
endmodule

// File: rtl/dma4_ctl.sv
module dma4_ctl
    import dma4_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic           rd,
    input  logic           page_sel,
    input  logic [3:0]     idx,
    input  logic [7:0]     wdata,
    input  logic [NCH-1:0] tc_hit,
    output ctl_t           st
);
    ctl_t st_d, st_q;
    logic chan_acc;
    logic ctl_wr;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        st_d.tc  = st_q.tc | tc_hit;
        chan_acc = (wr || rd) && !page_sel && !idx[3];
        ctl_wr   = wr && !page_sel && idx[3];
        if (chan_acc) st_d.ff = !st_q.ff;
        if (ctl_wr) begin
            case (idx[2:0])
                3'd0: begin
                    if ((wdata & CMD_REJECT) != 8'h00) st_d.err = 1'b1;
                    else                               st_d.cmd = wdata;
                end
                3'd1: begin
                    if (wdata[2]) st_d.req[wdata[1:0]] = 1'b1;
                    else begin
                        st_d.req[wdata[1:0]] = 1'b0;
                        st_d.tc[wdata[1:0]]  = 1'b0;
                    end
                end
                3'd2: st_d.mask[wdata[1:0]] = wdata[2];
                3'd4: st_d.ff = 1'b0;
                3'd5: begin
                    st_d.cmd  = '0;
                    st_d.req  = '0;
                    st_d.tc   = '0;
                    st_d.ff   = 1'b0;
                    st_d.mask = '1;
                end
                3'd6: st_d.mask = '0;
                3'd7: st_d.mask = wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    // R2
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr || rd) && !page_sel && !idx[3]) |=> (st_q.ff != $past(st_q.ff)));

    // R6
    cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !page_sel && idx == 4'h8 && (wdata & CMD_REJECT) != 8'h00)
        |=> (st_q.err && st_q.cmd == $past(st_q.cmd)));

    // R7
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !page_sel && idx == 4'h9 && !wdata[2])
        |=> (!st_q.req[$past(wdata[1:0])] && !st_q.tc[$past(wdata[1:0])]));

    // R10
    master_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !page_sel && idx == 4'hD)
        |=> (st_q.mask == '1 && !st_q.ff && st_q.req == '0 && st_q.cmd == 8'h00));

    // R12
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && !page_sel && idx[3]) |=> $stable(st_q.ff));
endmodule

// File: rtl/dma4_regfile.sv
module dma4_regfile
    import dma4_pkg::*;
#(
    parameter int PW = 8,
    localparam int XAW = REGW + PW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic                 bus_page,
    input  logic [3:0]           bus_idx,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 xfer_adv,
    input  logic [CHW-1:0]       xfer_chan,
    output logic [XAW-1:0]       xfer_addr,
    output logic [NCH-1:0]       chan_ready,
    output logic [NCH-1:0]       chan_mask,
    output logic [NCH*MODEW-1:0] chan_mode,
    output logic [7:0]           ctl_cmd,
    output logic                 cmd_err
);
    ctl_t            ctl;
    logic [NCH-1:0]  tc_hit;
    logic [REGW-1:0] cur_addr [NCH];
    logic [REGW-1:0] cur_cnt  [NCH];
    logic [PW-1:0]   page     [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        logic [MODEW-1:0] mode_k;
        dma4_chan #(.PW(PW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_base  (bus_wr && !bus_page && !bus_idx[3] && bus_idx[2:1] == CHW'(k)),
            .hi_byte  (ctl.ff),
            .sel_cnt  (bus_idx[0]),
            .wdata    (bus_wdata),
            .mode_wr  (bus_wr && !bus_page && bus_idx == 4'hB && bus_wdata[1:0] == CHW'(k)),
            .page_wr  (bus_wr && bus_page && bus_idx[1:0] == CHW'(k)),
            .adv      (xfer_adv && xfer_chan == CHW'(k)),
            .cur_addr (cur_addr[k]),
            .cur_cnt  (cur_cnt[k]),
            .page     (page[k]),
            .mode     (mode_k),
            .tc_hit   (tc_hit[k])
        );
        assign chan_mode[k*MODEW +: MODEW] = mode_k;
    end

    dma4_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .page_sel (bus_page),
        .idx      (bus_idx),
        .wdata    (bus_wdata),
        .tc_hit   (tc_hit),
        .st       (ctl)
    );

    logic [REGW-1:0] sel_word;

    always_comb begin
        sel_word  = bus_idx[0] ? cur_cnt[bus_idx[2:1]] : cur_addr[bus_idx[2:1]];
        bus_rdata = 8'hFF;
        if (bus_page) begin
            bus_rdata = 8'(page[bus_idx[1:0]]);
        end else if (!bus_idx[3]) begin
            bus_rdata = ctl.ff ? sel_word[15:8] : sel_word[7:0];
        end else if (bus_idx == 4'h8) begin
            bus_rdata = {ctl.req, ctl.tc};
        end else if (bus_idx == 4'hF) begin
            bus_rdata = {4'h0, ctl.mask};
        end
    end

    assign xfer_addr  = {page[xfer_chan], cur_addr[xfer_chan]};
    assign chan_ready = ctl.req & ~ctl.mask;
    assign chan_mask  = ctl.mask;
    assign ctl_cmd    = ctl.cmd;
    assign cmd_err    = ctl.err;

    // R14
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_ready & chan_mask) == '0);
endmodule

// File: tb/dma4_regfile_test.sv
`timescale 1ns/1ps
module dma4_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_page = 1'b0;
    logic [3:0]  bus_idx = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        xfer_adv = 1'b0;
    logic [1:0]  xfer_chan = '0;
    logic [23:0] xfer_addr;
    logic [3:0]  chan_ready, chan_mask;
    logic [23:0] chan_mode;
    logic [7:0]  ctl_cmd;
    logic        cmd_err;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    dma4_regfile uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic pg, input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_page = pg; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_page = 1'b0;
    endtask

    task automatic rd(input logic pg, input logic [3:0] idx, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_page = pg; bus_idx = idx;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_page = 1'b0;
    endtask

    task automatic adv(input logic [1:0] ch, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            xfer_adv = 1'b1; xfer_chan = ch;
            @(negedge clk);
            xfer_adv = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(0, 4'h8, v); chk("R1 status", v, 8'h00);
        rd(0, 4'hF, v); chk("R1 R11 mask read", v, 8'h0F);
        chk("R1 chan_mask", chan_mask, 4'hF);
        chk("R1 ctl_cmd", ctl_cmd, 8'h00);
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        wr(0, 4'hC, 8'h00);
        wr(0, 4'h0, 8'hAB); wr(0, 4'h0, 8'hCD);
        rd(0, 4'h0, v); chk("R2 low byte", v, 8'hAB);
        rd(0, 4'h0, v); chk("R2 high byte", v, 8'hCD);
        wr(0, 4'h0, 8'h11);
        wr(0, 4'hC, 8'h00);
        wr(0, 4'h0, 8'h22);
        wr(0, 4'hC, 8'h00);
        rd(0, 4'h0, v); chk("R2 clear pointer", v, 8'h22);
        wr(0, 4'hC, 8'h00);
        for (int p = 9; p <= 14; p++) begin
            rd(0, 4'(p), v); chk("R12 undefined read", v, 8'hFF);
        end
        rd(0, 4'h0, v); chk("R12 pointer kept", v, 8'h22);
        rd(0, 4'h0, v); chk("R2 high after kept", v, 8'hCD);
    endtask

    task automatic t_transfer();
        logic [7:0] v;
        wr(0, 4'hC, 8'h00);
        wr(1, 4'h1, 8'h5A);
        rd(1, 4'h1, v); chk("R13 page readback", v, 8'h5A);
        wr(0, 4'h2, 8'h34); wr(0, 4'h2, 8'h12);
        wr(0, 4'h3, 8'h02); wr(0, 4'h3, 8'h00);
        #1 xfer_chan = 2'd1;
        #1 chk("R13 xfer_addr", xfer_addr, 24'h5A1234);
        adv(1, 1);
        rd(0, 4'h2, v); chk("R4 addr low", v, 8'h35);
        rd(0, 4'h2, v); chk("R4 addr high", v, 8'h12);
        rd(0, 4'h3, v); chk("R4 count low", v, 8'h01);
        rd(0, 4'h3, v); chk("R4 count high", v, 8'h00);
        chk("R13 xfer_addr step", xfer_addr, 24'h5A1235);
        rd(0, 4'h8, v); chk("R5 no tc yet", v, 8'h00);
        adv(1, 2);
        rd(0, 4'h8, v); chk("R5 R11 tc set", v, 8'h02);
        rd(0, 4'h3, v); chk("R4 count wraps", v, 8'hFF);
        rd(0, 4'h3, v); chk("R4 count wraps hi", v, 8'hFF);
        wr(0, 4'h2, 8'h34); wr(0, 4'h2, 8'h12);
        rd(0, 4'h2, v); chk("R3 reload addr", v, 8'h34);
        rd(0, 4'h2, v); chk("R3 reload addr hi", v, 8'h12);
    endtask

    task automatic t_autoinit();
        logic [7:0] v;
        wr(0, 4'hC, 8'h00);
        wr(0, 4'hB, 8'h12);
        chk("R9 mode field", chan_mode[17:12], 6'h04);
        wr(0, 4'h5, 8'h01); wr(0, 4'h5, 8'h00);
        adv(2, 2);
        rd(0, 4'h5, v); chk("R5 autoinit reload", v, 8'h01);
        rd(0, 4'h5, v);
        rd(0, 4'h8, v); chk("R5 tc ch2", v, 8'h06);
    endtask

    task automatic t_command();
        wr(0, 4'h8, 8'h04);
        chk("R6 accepted", ctl_cmd, 8'h04);
        chk("R6 no err", cmd_err, 1'b0);
        wr(0, 4'h8, 8'h01);
        chk("R6 err pulse", cmd_err, 1'b1);
        chk("R6 rejected kept", ctl_cmd, 8'h04);
        @(negedge clk);
        chk("R6 err one cycle", cmd_err, 1'b0);
        wr(0, 4'h8, 8'h00);
        chk("R6 zero accepted", ctl_cmd, 8'h00);
    endtask

    task automatic t_request();
        logic [7:0] v;
        wr(0, 4'h9, 8'h07);
        rd(0, 4'h8, v); chk("R7 request set", v, 8'h86);
        chk("R14 masked", chan_ready, 4'h0);
        wr(0, 4'hA, 8'h03);
        chk("R8 R14 unmask ready", chan_ready, 4'h8);
        wr(0, 4'h9, 8'h01);
        rd(0, 4'h8, v); chk("R7 clear tc", v, 8'h84);
        wr(0, 4'h9, 8'h03);
        chk("R7 R14 request clear", chan_ready, 4'h0);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(0, 4'hF, 8'h05);
        rd(0, 4'hF, v); chk("R10 write all", v, 8'h05);
        wr(0, 4'hE, 8'h00);
        rd(0, 4'hF, v); chk("R10 clear all", v, 8'h00);
        wr(0, 4'hA, 8'h05);
        rd(0, 4'hF, v); chk("R8 single mask", v, 8'h02);
        wr(0, 4'h9, 8'h04);
        wr(0, 4'h8, 8'h04);
        wr(0, 4'hC, 8'h00);
        wr(0, 4'h0, 8'h99);
        wr(0, 4'hD, 8'h00);
        rd(0, 4'hF, v); chk("R10 reset mask", v, 8'h0F);
        rd(0, 4'h8, v); chk("R10 reset status", v, 8'h00);
        chk("R10 reset cmd", ctl_cmd, 8'h00);
        rd(0, 4'h0, v); chk("R10 reset pointer", v, 8'h99);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_transfer();
        t_autoinit();
        t_command();
        t_request();
        t_mask();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule